// File: doc/BRIEF.md
# USB Dual-Role Port Role Switch Controller

This block chooses and applies the host or peripheral role of a dual-role USB 2.0 port. It drives the line pulldown controls, a transceiver no-drive control, a peripheral-mode bit and the VBUS drive enable. It decides the role from the synchronized ID pin and VBUS-valid level, or applies a role that software requests. Each kind of role change runs as a short, fixed series of output steps, one step per clock, so the transceiver never sees an illegal mix of settings.

When enabled on a dual-role port, the block first turns on both pulldown enables and the ID pull-up. It then waits a parameterized settle time, clears all change status, arms the change interrupt and runs a first automatic recognition. After that, a change on the synchronized ID or session-valid input sets a sticky status bit. When that bit's enable is set, the block raises the interrupt and re-runs recognition. Software clears status bits by writing ones. With the `LEVEL_SENSE` variant, the B-device indication is the ID level while VBUS is valid and its inverse while it is not.

Top module: `otg_role_ctrl`

## Requirements
- R1: After reset every pulldown, pulldown enable, ID pull-up, no-drive and VBUS output is 0. The peripheral-mode bit is 1 and the role status reads 0 (not host). Status, interrupt, busy and error are all 0.
- R2: Host role means D+ pulldown 1, D- pulldown 1 and peripheral-mode 0. Automatic recognition of an A-device (indication 0) gives host with VBUS drive 1.
- R3: Peripheral role means D+ pulldown 0, D- pulldown 1 and peripheral-mode 1. A B-device moving to peripheral, by request or by recognition, has VBUS drive 0.
- R4: A host request from a B-device in peripheral role takes three clocks. The first clock sets no-drive. The second applies host line settings with VBUS drive 0. The third releases no-drive.
- R5: A peripheral request from an A-device in host role gives peripheral line settings and leaves VBUS drive at 1.
- R6: A host request from an A-device in peripheral role holds the change interrupt low for two clocks. Host settings with VBUS drive 1 are applied in the second of those clocks. The interrupt is unmasked in the third.
- R7: With `LEVEL_SENSE`=1, the B-device indication is the synchronized ID when synchronized VBUS-valid is 1, and its inverse otherwise. Recognition picks host when the indication is 0 and peripheral when it is 1.
- R8: Status bit 0 is set by a change of synchronized ID and bit 1 by a change of synchronized session-valid. Each bit stays set until software writes a 1 to it. Writing 0 to a bit leaves it set. The interrupt is high while any set bit has its enable bit at 1.
- R9: A change whose enable bit is 0 still sets its status bit, but raises no interrupt and starts no recognition.
- R10: A request is rejected with a one-clock error pulse, and the outputs left as they were, in three cases: it asks for the current role, the port is not dual-role, or the block is not initialized.
- R11: Enabling sets both pulldown enables and the ID pull-up, with D+ pulldown 0 and D- pulldown 1. The block then stays busy for `SETTLE_CYCLES` clocks, clears all status and applies the first recognition.
- R12: A request that arrives while a step sequence runs is held. It is carried out once the sequence ends.
- R13: ID and session-valid pass through two synchronizer flops. A change driven on a pin shows in the status on the third rising clock edge after it is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable_i | input | 1 | Block enable; a rising enable starts initialization |
| dual_role_i | input | 1 | Port is configured as dual-role |
| id_pin_i | input | 1 | Raw ID pin level |
| vbus_valid_i | input | 1 | Raw VBUS-valid flag |
| sess_valid_i | input | 1 | Raw session-valid flag |
| role_req_i | input | 1 | Role request strobe |
| role_req_host_i | input | 1 | Requested role: 1 host, 0 peripheral |
| chg_irq_en_i | input | 2 | Per-bit enable of the change status |
| chg_clr_we_i | input | 1 | Write strobe for status clear |
| chg_clr_data_i | input | 2 | Write-one-to-clear data |
| dp_pd_en_o | output | 1 | D+ pulldown enable |
| dm_pd_en_o | output | 1 | D- pulldown enable |
| dp_pd_o | output | 1 | D+ pulldown on |
| dm_pd_o | output | 1 | D- pulldown on |
| id_pullup_o | output | 1 | ID sampling pull-up enable |
| no_drive_o | output | 1 | Transceiver no-drive control |
| peri_mode_o | output | 1 | Peripheral-mode bit (0 = host) |
| vbus_drv_o | output | 1 | VBUS drive enable |
| role_host_o | output | 1 | Role status, 1 when host |
| busy_o | output | 1 | Settle or step sequence in progress |
| req_err_o | output | 1 | One-clock pulse on a rejected request |
| chg_status_o | output | 2 | Sticky change status {session, ID} |
| chg_irq_o | output | 1 | Change interrupt |

## Verification
On every cycle, the assertions check four properties. Status bits stay set until cleared, and a change always sets its bit. A no-drive window opens only from peripheral mode and closes in host mode. The interrupt mask window starts in peripheral and ends in host with VBUS on. An error pulse comes only from the idle or initialized-ready states, and any ready state has its pulldown enables, ID pull-up and D- pulldown on. Only the bench scenarios show the exact step order of each role transition. They also show the settle length, the VBUS inversion of the ID sense, requests held across a running sequence, and the synchronizer latency.

// File: rtl/otg_role_pkg.sv
package otg_role_pkg;

  typedef enum logic [3:0] {
    ST_OFF,
    ST_SETTLE,
    ST_ARM,
    ST_READY,
    ST_BH_APPLY,
    ST_BH_DONE,
    ST_AH_APPLY,
    ST_AH_DONE
  } seq_state_e;

  typedef struct packed {
    logic dp_pd;
    logic dm_pd;
    logic peri;
    logic vbus;
  } line_cfg_t;

  // B-device indication; with level sensing the ID sense flips when VBUS is absent
  function automatic logic dev_is_b(input logic id, input logic vbus_ok,
                                    input logic level_sense);
    if (level_sense) return vbus_ok ? id : ~id;
    return id;
  endfunction

  function automatic line_cfg_t host_cfg(input logic vbus_on);
    line_cfg_t c;
    c.dp_pd = 1'b1;
    c.dm_pd = 1'b1;
    c.peri  = 1'b0;
    c.vbus  = vbus_on;
    return c;
  endfunction

  function automatic line_cfg_t peri_cfg(input logic vbus_on);
    line_cfg_t c;
    c.dp_pd = 1'b0;
    c.dm_pd = 1'b1;
    c.peri  = 1'b1;
    c.vbus  = vbus_on;
    return c;
  endfunction

endpackage

// File: rtl/otg_in_sync.sv
module otg_in_sync #(
  parameter int NBITS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NBITS-1:0] raw_i,
  output logic [NBITS-1:0] sync_o,
  output logic [NBITS-1:0] chg_o
);

  logic [NBITS-1:0] meta_q;
  logic [NBITS-1:0] sync_q;
  logic [NBITS-1:0] prev_q;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[i] <= 1'b0;
        sync_q[i] <= 1'b0;
        prev_q[i] <= 1'b0;
      end else begin
        meta_q[i] <= raw_i[i];
        sync_q[i] <= meta_q[i];
        prev_q[i] <= sync_q[i];
      end
    end
    assign chg_o[i] = sync_q[i] ^ prev_q[i];
  end

  assign sync_o = sync_q;

endmodule

// File: rtl/otg_chg_status.sv
module otg_chg_status #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] set_i,
  input  logic          clr_we_i,
  input  logic [NB-1:0] clr_data_i,
  input  logic          clr_all_i,
  input  logic [NB-1:0] en_i,
  input  logic          armed_i,
  input  logic          mask_i,
  output logic [NB-1:0] status_o,
  output logic          irq_o,
  output logic          fire_o
);

  logic [NB-1:0] st_q;
  logic [NB-1:0] clr_bits;
  logic          open_gate;

  assign clr_bits  = clr_we_i ? clr_data_i : '0;
  assign open_gate = armed_i & ~mask_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         st_q <= '0;
    else if (clr_all_i) st_q <= '0;
    else                st_q <= (st_q & ~clr_bits) | set_i;
  end

  assign status_o = st_q;
  assign irq_o    = open_gate & (|(st_q & en_i));
  assign fire_o   = open_gate & (|(set_i & en_i));

  for (genvar i = 0; i < NB; i++) begin : g_chk
    p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] && !clr_all_i && !(clr_we_i && clr_data_i[i])) |=> st_q[i]);
    p_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i[i] && !clr_all_i) |=> st_q[i]);
  end

endmodule

// File: rtl/otg_role_seq.sv
module otg_role_seq
  import otg_role_pkg::*;
#(
  parameter int   SETTLE_CYCLES = 2000000,
  parameter logic LEVEL_SENSE   = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dual_role_i,
  input  logic id_s_i,
  input  logic vbus_s_i,
  input  logic fire_i,
  input  logic req_valid_i,
  input  logic req_host_i,
  output line_cfg_t line_o,
  output logic pd_en_o,
  output logic id_pullup_o,
  output logic nodrv_o,
  output logic mask_o,
  output logic armed_o,
  output logic clr_all_o,
  output logic err_o,
  output logic busy_o
);

  localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  seq_state_e       state_q;
  line_cfg_t        line_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pd_en_q, idpu_q, nodrv_q, mask_q, armed_q, clr_q, err_q;
  logic             recog_pend_q, req_pend_q, req_host_q;
  logic             dev_b;
  logic             is_host;
  line_cfg_t        recog_cfg;

  if (LEVEL_SENSE) begin : g_level
    assign dev_b = dev_is_b(id_s_i, vbus_s_i, 1'b1);
  end else begin : g_plain
    assign dev_b = dev_is_b(id_s_i, vbus_s_i, 1'b0);
  end

  assign is_host   = ~line_q.peri;
  assign recog_cfg = dev_b ? peri_cfg(1'b0) : host_cfg(1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_OFF;
      line_q       <= peri_cfg(1'b0);
      line_q.dm_pd <= 1'b0;
      cnt_q        <= '0;
      pd_en_q      <= 1'b0;
      idpu_q       <= 1'b0;
      nodrv_q      <= 1'b0;
      mask_q       <= 1'b0;
      armed_q      <= 1'b0;
      clr_q        <= 1'b0;
      err_q        <= 1'b0;
      recog_pend_q <= 1'b0;
      req_pend_q   <= 1'b0;
      req_host_q   <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      err_q <= 1'b0;
      case (state_q)
        ST_OFF: begin
          if (req_pend_q) begin
            err_q      <= 1'b1;
            req_pend_q <= 1'b0;
          end
          if (en_i && dual_role_i) begin
            pd_en_q      <= 1'b1;
            idpu_q       <= 1'b1;
            line_q.dp_pd <= 1'b0;
            line_q.dm_pd <= 1'b1;
            cnt_q        <= CNT_LOAD;
            state_q      <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (cnt_q == '0) begin
            clr_q   <= 1'b1;
            armed_q <= 1'b1;
            state_q <= ST_ARM;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ARM: begin
          line_q       <= recog_cfg;
          recog_pend_q <= 1'b0;
          state_q      <= ST_READY;
        end
        ST_READY: begin
          if (!en_i || !dual_role_i) begin
            armed_q <= 1'b0;
            state_q <= ST_OFF;
          end else if (recog_pend_q) begin
            line_q       <= recog_cfg;
            recog_pend_q <= 1'b0;
          end else if (req_pend_q) begin
            req_pend_q <= 1'b0;
            if (req_host_q == is_host) begin
              err_q <= 1'b1;
            end else if (req_host_q) begin
              if (dev_b) begin
                nodrv_q <= 1'b1;
                state_q <= ST_BH_APPLY;
              end else begin
                mask_q  <= 1'b1;
                state_q <= ST_AH_APPLY;
              end
            end else begin
              line_q <= peri_cfg(~dev_b);
            end
          end
        end
        ST_BH_APPLY: begin
          line_q  <= host_cfg(1'b0);
          state_q <= ST_BH_DONE;
        end
        ST_BH_DONE: begin
          nodrv_q <= 1'b0;
          state_q <= ST_READY;
        end
        ST_AH_APPLY: begin
          line_q  <= host_cfg(1'b1);
          state_q <= ST_AH_DONE;
        end
        ST_AH_DONE: begin
          mask_q  <= 1'b0;
          state_q <= ST_READY;
        end
        default: state_q <= ST_OFF;
      endcase
      if (fire_i) recog_pend_q <= 1'b1;
      if (req_valid_i) begin
        req_pend_q <= 1'b1;
        req_host_q <= req_host_i;
      end
    end
  end

  assign line_o      = line_q;
  assign pd_en_o     = pd_en_q;
  assign id_pullup_o = idpu_q;
  assign nodrv_o     = nodrv_q;
  assign mask_o      = mask_q;
  assign armed_o     = armed_q;
  assign clr_all_o   = clr_q;
  assign err_o       = err_q;
  assign busy_o      = (state_q != ST_OFF) && (state_q != ST_READY);

  p_nodrv_from_peri_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nodrv_q) |-> line_q.peri);
  p_nodrv_to_host_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nodrv_q) |-> !line_q.peri);
  p_mask_from_peri_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mask_q) |-> line_q.peri);
  p_mask_to_host_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mask_q) |-> (!line_q.peri && line_q.vbus));
  p_err_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> ($past(state_q) == ST_READY || $past(state_q) == ST_OFF));
  p_ready_lines_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_READY) |-> (pd_en_q && idpu_q && line_q.dm_pd));

endmodule

// File: rtl/otg_role_ctrl.sv
module otg_role_ctrl
  import otg_role_pkg::*;
#(
  parameter int   SETTLE_CYCLES = 2000000,
  parameter logic LEVEL_SENSE   = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       dual_role_i,
  input  logic       id_pin_i,
  input  logic       vbus_valid_i,
  input  logic       sess_valid_i,
  input  logic       role_req_i,
  input  logic       role_req_host_i,
  input  logic [1:0] chg_irq_en_i,
  input  logic       chg_clr_we_i,
  input  logic [1:0] chg_clr_data_i,
  output logic       dp_pd_en_o,
  output logic       dm_pd_en_o,
  output logic       dp_pd_o,
  output logic       dm_pd_o,
  output logic       id_pullup_o,
  output logic       no_drive_o,
  output logic       peri_mode_o,
  output logic       vbus_drv_o,
  output logic       role_host_o,
  output logic       busy_o,
  output logic       req_err_o,
  output logic [1:0] chg_status_o,
  output logic       chg_irq_o
);

  localparam int NSYNC = 3;  // [0] ID, [1] session-valid, [2] VBUS-valid

  logic [NSYNC-1:0] sync_v, chg_v;
  logic             fire, armed, mask, clr_all, pd_en;
  line_cfg_t        line;
  logic             unused_bits;

  otg_in_sync #(.NBITS(NSYNC)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_i  ({vbus_valid_i, sess_valid_i, id_pin_i}),
    .sync_o (sync_v),
    .chg_o  (chg_v)
  );

  otg_chg_status #(.NB(2)) u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_i      (chg_v[1:0]),
    .clr_we_i   (chg_clr_we_i),
    .clr_data_i (chg_clr_data_i),
    .clr_all_i  (clr_all),
    .en_i       (chg_irq_en_i),
    .armed_i    (armed),
    .mask_i     (mask),
    .status_o   (chg_status_o),
    .irq_o      (chg_irq_o),
    .fire_o     (fire)
  );

  otg_role_seq #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .LEVEL_SENSE   (LEVEL_SENSE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (enable_i),
    .dual_role_i (dual_role_i),
    .id_s_i      (sync_v[0]),
    .vbus_s_i    (sync_v[2]),
    .fire_i      (fire),
    .req_valid_i (role_req_i),
    .req_host_i  (role_req_host_i),
    .line_o      (line),
    .pd_en_o     (pd_en),
    .id_pullup_o (id_pullup_o),
    .nodrv_o     (no_drive_o),
    .mask_o      (mask),
    .armed_o     (armed),
    .clr_all_o   (clr_all),
    .err_o       (req_err_o),
    .busy_o      (busy_o)
  );

  assign unused_bits = ^{sync_v[1], chg_v[2]};

  assign dp_pd_en_o  = pd_en;
  assign dm_pd_en_o  = pd_en;
  assign dp_pd_o     = line.dp_pd;
  assign dm_pd_o     = line.dm_pd;
  assign peri_mode_o = line.peri;
  assign vbus_drv_o  = line.vbus;
  assign role_host_o = ~line.peri;

endmodule

// File: tb/tb_otg_role_ctrl.sv
module tb_otg_role_ctrl;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic enable = 1'b0, dual = 1'b1, id = 1'b0, vbus = 1'b0, sess = 1'b0;
  logic req = 1'b0, req_host = 1'b0;
  logic [1:0] irq_en = 2'b00;
  logic clr_we = 1'b0;
  logic [1:0] clr_data = 2'b00;
  logic dp_pd_en, dm_pd_en, dp_pd, dm_pd, id_pullup, no_drive, peri_mode;
  logic vbus_drv, role_host, busy, req_err, chg_irq;
  logic [1:0] chg_status;

  otg_role_ctrl #(.SETTLE_CYCLES(16), .LEVEL_SENSE(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .enable_i(enable), .dual_role_i(dual),
    .id_pin_i(id), .vbus_valid_i(vbus), .sess_valid_i(sess),
    .role_req_i(req), .role_req_host_i(req_host), .chg_irq_en_i(irq_en),
    .chg_clr_we_i(clr_we), .chg_clr_data_i(clr_data),
    .dp_pd_en_o(dp_pd_en), .dm_pd_en_o(dm_pd_en), .dp_pd_o(dp_pd),
    .dm_pd_o(dm_pd), .id_pullup_o(id_pullup), .no_drive_o(no_drive),
    .peri_mode_o(peri_mode), .vbus_drv_o(vbus_drv), .role_host_o(role_host),
    .busy_o(busy), .req_err_o(req_err), .chg_status_o(chg_status),
    .chg_irq_o(chg_irq)
  );

  // observed vector: line[11:6] irq[5] status[4:3] busy[2] err[1] init[0]
  wire [11:0] obs = {dp_pd, dm_pd, no_drive, peri_mode, vbus_drv, role_host,
                     chg_irq, chg_status, busy, req_err,
                     dp_pd_en & dm_pd_en & id_pullup};

  localparam logic [11:0] C_LINE = 12'hFC0;
  localparam logic [11:0] C_IRQ  = 12'h020;
  localparam logic [11:0] C_ST   = 12'h018;
  localparam logic [11:0] C_BUSY = 12'h004;
  localparam logic [11:0] C_ERR  = 12'h002;
  localparam logic [11:0] C_INIT = 12'h001;

  typedef struct {
    string       tag;
    logic [11:0] exp;
    logic [11:0] care;
  } item_t;

  item_t sb_q[$];
  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  function automatic logic [11:0] ln(logic dp, logic dm, logic nd, logic pe, logic vb);
    return {dp, dm, nd, pe, vb, ~pe, 6'b0};
  endfunction

  function automatic logic [11:0] fl(logic irq, logic [1:0] st, logic bz, logic er, logic in);
    return {6'b0, irq, st, bz, er, in};
  endfunction

  // monitor: pops one expected item per falling edge and compares
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_vec++;
        if (((obs ^ it.exp) & it.care) != 12'h000) begin
          n_bad++;
          $display("FAIL %s got=%b exp=%b care=%b", it.tag, obs, it.exp, it.care);
        end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic expect_obs(input string tag, input logic [11:0] e, input logic [11:0] c);
    sb_q.push_back('{tag, e, c});
    @(negedge clk);
    #1;
  endtask

  task automatic pulse_req(input logic h);
    req = 1'b1;
    req_host = h;
    tick(1);
    req = 1'b0;
  endtask

  task automatic clear_st(input logic [1:0] d);
    clr_we = 1'b1;
    clr_data = d;
    tick(1);
    clr_we = 1'b0;
    clr_data = 2'b00;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    tick(1);
    expect_obs("R1 reset state", ln(0,0,0,1,0) | fl(0,2'b00,0,0,0), 12'hFFF);

    // R10: request before initialization
    pulse_req(1'b1);
    tick(1);
    expect_obs("R10 reject when not initialized", ln(0,0,0,1,0) | fl(0,0,0,1,0), C_LINE|C_ERR);
    tick(1);
    expect_obs("R10 error is one pulse", 12'h000, C_ERR);

    // R11: initialization
    id = 1'b1; vbus = 1'b1; irq_en = 2'b11;
    tick(4);
    enable = 1'b1;
    tick(1);
    expect_obs("R11 init enables and busy", ln(0,1,0,1,0) | fl(0,0,1,0,1), C_LINE|C_BUSY|C_INIT);
    sess = 1'b1;
    tick(3);
    expect_obs("R9 status set while unarmed, no irq", fl(0,2'b11,1,0,1), C_IRQ|C_ST|C_BUSY);
    tick(12);
    expect_obs("R11 still settling", fl(0,0,1,0,1), C_BUSY);
    tick(2);
    expect_obs("R11 settle done, status cleared, B-device peripheral",
               ln(0,1,0,1,0) | fl(0,2'b00,0,0,1), 12'hFFF);

    // R10: same role
    pulse_req(1'b0);
    tick(1);
    expect_obs("R10 reject same role", ln(0,1,0,1,0) | fl(0,0,0,1,0), C_LINE|C_ERR);

    // R4: B-device to host
    pulse_req(1'b1);
    tick(1);
    expect_obs("R4 step1 no-drive on", ln(0,1,1,1,0) | fl(0,0,1,0,1), C_LINE|C_BUSY);
    tick(1);
    expect_obs("R4 step2 host lines vbus off", ln(1,1,1,0,0) | fl(0,0,1,0,1), C_LINE|C_BUSY);
    tick(1);
    expect_obs("R4 step3 no-drive released", ln(1,1,0,0,0) | fl(0,0,0,0,1), C_LINE|C_BUSY|C_ERR);

    // R3: B-host to peripheral
    pulse_req(1'b0);
    tick(1);
    expect_obs("R3 peripheral lines vbus off", ln(0,1,0,1,0) | fl(0,0,0,0,1), C_LINE|C_ERR|C_INIT);

    // R12: request held during a sequence
    pulse_req(1'b1);
    tick(1);
    req = 1'b1; req_host = 1'b0;
    tick(1);
    req = 1'b0;
    tick(1);
    expect_obs("R12 sequence completes first", ln(1,1,0,0,0) | fl(0,0,0,0,1), C_LINE|C_BUSY);
    tick(1);
    expect_obs("R12 held request applied", ln(0,1,0,1,0) | fl(0,0,0,0,1), C_LINE|C_ERR);

    // R7/R2: automatic recognition to A-device host
    id = 1'b0;
    tick(3);
    expect_obs("R8 id change sets status, irq", ln(0,1,0,1,0) | fl(1,2'b01,0,0,1), C_LINE|C_IRQ|C_ST);
    tick(1);
    expect_obs("R2 recognition host vbus on", ln(1,1,0,0,1) | fl(1,2'b01,0,0,1), C_LINE|C_IRQ|C_ST);

    // R8: write-one-to-clear
    clear_st(2'b10);
    expect_obs("R8 writing zero keeps bit", fl(1,2'b01,0,0,1), C_IRQ|C_ST);
    clear_st(2'b01);
    expect_obs("R8 writing one clears bit", fl(0,2'b00,0,0,1), C_IRQ|C_ST);

    // R7: inverted ID sense while VBUS not valid
    vbus = 1'b0;
    tick(4);
    expect_obs("R7 vbus alone changes nothing", ln(1,1,0,0,1) | fl(0,2'b00,0,0,1), C_LINE|C_ST);
    id = 1'b1;
    tick(4);
    expect_obs("R7 id=1 without vbus gives host", ln(1,1,0,0,1) | fl(1,2'b01,0,0,1), C_LINE|C_ST);
    id = 1'b0;
    tick(4);
    expect_obs("R7 id=0 without vbus gives peripheral", ln(0,1,0,1,0) | fl(1,2'b01,0,0,1), C_LINE|C_ST);
    clear_st(2'b11);

    // R5: A-device host to peripheral keeps VBUS
    vbus = 1'b1;
    tick(3);
    sess = 1'b0;
    tick(4);
    expect_obs("R8 session change recognition to A host", ln(1,1,0,0,1) | fl(1,2'b10,0,0,1), C_LINE|C_IRQ|C_ST);
    pulse_req(1'b0);
    tick(1);
    expect_obs("R5 A peripheral keeps vbus", ln(0,1,0,1,1) | fl(1,2'b10,0,0,1), C_LINE|C_IRQ|C_ERR);

    // R6: A-device peripheral to host masks interrupt
    pulse_req(1'b1);
    tick(1);
    expect_obs("R6 irq masked step1", ln(0,1,0,1,1) | fl(0,2'b10,1,0,1), C_LINE|C_IRQ|C_BUSY);
    tick(1);
    expect_obs("R6 host applied while masked", ln(1,1,0,0,1) | fl(0,2'b10,1,0,1), C_LINE|C_IRQ|C_BUSY);
    tick(1);
    expect_obs("R6 irq unmasked", ln(1,1,0,0,1) | fl(1,2'b10,0,0,1), C_LINE|C_IRQ|C_BUSY);

    // R9: disabled enable bits
    irq_en = 2'b00;
    clear_st(2'b11);
    id = 1'b1;
    tick(5);
    expect_obs("R9 disabled change: status only", ln(1,1,0,0,1) | fl(0,2'b01,0,0,1), C_LINE|C_IRQ|C_ST);

    // R10: port not dual-role
    dual = 1'b0;
    tick(1);
    pulse_req(1'b0);
    tick(1);
    expect_obs("R10 reject when not dual-role", ln(1,1,0,0,1) | fl(0,0,0,1,0), C_LINE|C_ERR);

    // R13: synchronizer latency
    clear_st(2'b11);
    id = 1'b0;
    tick(2);
    expect_obs("R13 no status after two edges", fl(0,2'b00,0,0,0), C_ST);
    tick(1);
    expect_obs("R13 status on third edge", fl(0,2'b01,0,0,0), C_ST);

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog all requirements got=hung exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule